// File: doc/BRIEF.md
# Data abort fault status recorder

This block records data-abort events for a small processor core. On an abort cycle the core raises a one-cycle strobe. Together with it the core presents a vector of fault causes, any number of which may be set at once. The core also presents a qualifier bit that separates page-level faults from section-level faults. For external aborts on translation, the same bit separates second-level from first-level faults. The remaining inputs carry a domain number, the effective data address, the address of the faulting instruction and the address of the next instruction.

The block picks one winning cause by fixed priority. It writes a fault status register, which holds a 5-bit status code and a 4-bit domain field. It also loads a fault address register when the winning cause gives a meaningful address, forms the link value for the abort handler and marks whether the abort is precise and recoverable. Precise aborts link to the faulting instruction plus 8. Imprecise aborts link to the next instruction plus 4. A one-cycle pulse reports each recorded abort.

Top module: `dabt_status_rec`

## Requirements
- R1: While `rst_n` is low, `fsr_code`, `fsr_domain`, `far_q`, `link_q`, `precise_q` and `abort_taken` are all zero.
- R2: Cause bit positions are: 0 alignment, 1 external abort on translation, 2 translation, 3 domain, 4 permission, 5 lock, 6 imprecise external, 7 cache parity. The recorded code for each cause is as follows, with the first value for `is_page`=0 and the second for `is_page`=1:
  - alignment 00001
  - external on translation 01100/01110
  - translation 00101/00111
  - domain 01001/01011
  - permission 01101/01111
  - lock 10100
  - imprecise external 10110
  - parity 11000
- R3: When several cause bits are set, the lowest-numbered bit wins.
- R4: `far_q` takes `eff_addr` when the winner is cause 0 to 4. For causes 5 to 7, `far_q` keeps its previous value.
- R5: `fsr_domain` takes `domain_in` when the winner is domain or permission. It also does so when the winner is translation or external-on-translation with `is_page`=1. In every other case `fsr_domain` keeps its previous value.
- R6: When the winner is cause 0 to 5, `precise_q` is 1 and `link_q` is `fault_pc`+8.
- R7: When the winner is cause 6 or 7, `precise_q` is 0 and `link_q` is `next_pc`+4.
- R8: The registers update on the clock edge at which `abt_vld` is high and at least one cause is set. `abort_taken` is high during the cycle that follows that edge and only then.
- R9: If `abt_vld` is high while all cause bits are zero, no register changes and `abort_taken` stays low.
- R10: Cause bits and qualifiers presented while `abt_vld` is low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abt_vld | input | 1 | Abort strobe |
| cause | input | 8 | Fault cause vector, bit 0 highest priority |
| is_page | input | 1 | Page / second-level qualifier |
| domain_in | input | 4 | Domain of the access |
| eff_addr | input | AW | Effective data address |
| fault_pc | input | AW | Address of faulting instruction |
| next_pc | input | AW | Address of next instruction |
| fsr_code | output | 5 | Recorded status code |
| fsr_domain | output | 4 | Recorded domain |
| far_q | output | AW | Fault address register |
| link_q | output | AW | Abort link value |
| precise_q | output | 1 | Last abort precise and recoverable |
| abort_taken | output | 1 | One-cycle pulse per recorded abort |

## Verification
The assertions check four things on every cycle:
- an idle or empty strobe freezes all state and produces no pulse;
- every pulse carries a legal code;
- the link offset agrees with the precise flag;
- alignment and lock winners load or keep the fault address as required.

Only the bench's scenarios can show the exact per-cause code table under every priority mix, and that the domain field is loaded or held for each cause and qualifier combination. The bench shows these by comparing every output against its behavioural model after each edge.

// File: rtl/dabt_pkg.sv
package dabt_pkg;
  localparam int NCAUSE = 8;
  localparam int CW     = 5;
  localparam int DW     = 4;

  typedef enum logic [2:0] {
    C_ALIGN = 3'd0,
    C_EXTX  = 3'd1,
    C_XLAT  = 3'd2,
    C_DOM   = 3'd3,
    C_PERM  = 3'd4,
    C_LOCK  = 3'd5,
    C_IMPX  = 3'd6,
    C_PAR   = 3'd7
  } cause_e;

  typedef struct packed {
    logic [CW-1:0] code;
    logic          addr_ok;
    logic          dom_ok;
    logic          precise;
  } verdict_t;
endpackage

// File: rtl/dabt_prio.sv
module dabt_prio #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    // scan downward so the lowest set bit is the final assignment
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dabt_encode.sv
module dabt_encode
  import dabt_pkg::*;
(
  input  cause_e   which,
  input  logic     is_page,
  output verdict_t v
);
  always_comb begin
    v = '0;
    case (which)
      C_ALIGN: begin v.code = 5'b00001; v.addr_ok = 1'b1; v.precise = 1'b1; end
      C_EXTX:  begin v.code = is_page ? 5'b01110 : 5'b01100; v.addr_ok = 1'b1;
                     v.dom_ok = is_page; v.precise = 1'b1; end
      C_XLAT:  begin v.code = is_page ? 5'b00111 : 5'b00101; v.addr_ok = 1'b1;
                     v.dom_ok = is_page; v.precise = 1'b1; end
      C_DOM:   begin v.code = is_page ? 5'b01011 : 5'b01001; v.addr_ok = 1'b1;
                     v.dom_ok = 1'b1; v.precise = 1'b1; end
      C_PERM:  begin v.code = is_page ? 5'b01111 : 5'b01101; v.addr_ok = 1'b1;
                     v.dom_ok = 1'b1; v.precise = 1'b1; end
      C_LOCK:  begin v.code = 5'b10100; v.precise = 1'b1; end
      C_IMPX:  begin v.code = 5'b10110; end
      C_PAR:   begin v.code = 5'b11000; end
      default: v = '0;
    endcase
  end
endmodule

// File: rtl/dabt_link.sv
module dabt_link #(
  parameter int AW = 32
) (
  input  logic          precise,
  input  logic [AW-1:0] fault_pc,
  input  logic [AW-1:0] next_pc,
  output logic [AW-1:0] link
);
  localparam logic [AW-1:0] PRE_OFS = AW'(8);
  localparam logic [AW-1:0] IMP_OFS = AW'(4);

  always_comb begin
    link = precise ? (fault_pc + PRE_OFS) : (next_pc + IMP_OFS);
  end
endmodule

// File: rtl/dabt_status_rec.sv
module dabt_status_rec
  import dabt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abt_vld,
  input  logic [NCAUSE-1:0] cause,
  input  logic              is_page,
  input  logic [DW-1:0]     domain_in,
  input  logic [AW-1:0]     eff_addr,
  input  logic [AW-1:0]     fault_pc,
  input  logic [AW-1:0]     next_pc,
  output logic [CW-1:0]     fsr_code,
  output logic [DW-1:0]     fsr_domain,
  output logic [AW-1:0]     far_q,
  output logic [AW-1:0]     link_q,
  output logic              precise_q,
  output logic              abort_taken
);
  localparam int IW = $clog2(NCAUSE);

  logic          any_cause;
  logic [IW-1:0] win_idx;
  verdict_t      verdict;
  logic [AW-1:0] link_val;
  logic          take;

  logic [CW-1:0] code_d;
  logic [DW-1:0] dom_d;
  logic [AW-1:0] far_d;
  logic [AW-1:0] link_d;
  logic          precise_d;

  dabt_prio #(.N(NCAUSE)) u_prio (
    .req (cause),
    .hit (any_cause),
    .idx (win_idx)
  );

  dabt_encode u_enc (
    .which   (cause_e'(win_idx)),
    .is_page (is_page),
    .v       (verdict)
  );

  dabt_link #(.AW(AW)) u_link (
    .precise  (verdict.precise),
    .fault_pc (fault_pc),
    .next_pc  (next_pc),
    .link     (link_val)
  );

  assign take = abt_vld & any_cause;

  always_comb begin
    code_d    = fsr_code;
    dom_d     = fsr_domain;
    far_d     = far_q;
    link_d    = link_q;
    precise_d = precise_q;
    if (take) begin
      code_d    = verdict.code;
      link_d    = link_val;
      precise_d = verdict.precise;
      if (verdict.addr_ok) far_d = eff_addr;
      if (verdict.dom_ok)  dom_d = domain_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_code    <= '0;
      fsr_domain  <= '0;
      far_q       <= '0;
      link_q      <= '0;
      precise_q   <= 1'b0;
      abort_taken <= 1'b0;
    end else begin
      fsr_code    <= code_d;
      fsr_domain  <= dom_d;
      far_q       <= far_d;
      link_q      <= link_d;
      precise_q   <= precise_d;
      abort_taken <= take;
    end
  end
endmodule

// File: rtl/dabt_checker.sv
module dabt_checker
  import dabt_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abt_vld,
  input logic [NCAUSE-1:0] cause,
  input logic [AW-1:0]     eff_addr,
  input logic [AW-1:0]     fault_pc,
  input logic [AW-1:0]     next_pc,
  input logic [CW-1:0]     fsr_code,
  input logic [DW-1:0]     fsr_domain,
  input logic [AW-1:0]     far_q,
  input logic [AW-1:0]     link_q,
  input logic              precise_q,
  input logic              abort_taken
);
  logic code_legal;
  always_comb begin
    case (fsr_code)
      5'b00001, 5'b01100, 5'b01110, 5'b00101, 5'b00111, 5'b01001,
      5'b01011, 5'b01101, 5'b01111, 5'b10100, 5'b10110, 5'b11000:
        code_legal = 1'b1;
      default: code_legal = 1'b0;
    endcase
  end

  // R8: a qualifying strobe is followed by the pulse
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_vld && |cause) |=> abort_taken);

  // R9 / R10: no qualifying strobe means frozen state and no pulse
  a_r9_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(abt_vld && |cause) |=> (!abort_taken && $stable(fsr_code) && $stable(fsr_domain)
                               && $stable(far_q) && $stable(link_q) && $stable(precise_q)));

  // R2: every recorded abort carries a legal code
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    abort_taken |-> code_legal);

  // R6: precise winners link to faulting instruction + 8
  a_r6_precise_link: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_vld && |cause[5:0]) |=> (precise_q && link_q == $past(fault_pc) + AW'(8)));

  // R7: imprecise winners link to next instruction + 4
  a_r7_imprecise_link: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_vld && cause[5:0] == '0 && |cause[7:6]) |=> (!precise_q && link_q == $past(next_pc) + AW'(4)));

  // R3 / R4: alignment wins over anything and loads the address
  a_r3_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_vld && cause[0]) |=> (fsr_code == 5'b00001 && far_q == $past(eff_addr)));

  // R4: a lock winner keeps the fault address
  a_r4_lock_keeps_far: assert property (@(posedge clk) disable iff (!rst_n)
    (abt_vld && cause[5:0] == 6'b100000) |=> (fsr_code == 5'b10100 && $stable(far_q)));
endmodule

bind dabt_status_rec dabt_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abt_vld     (abt_vld),
  .cause       (cause),
  .eff_addr    (eff_addr),
  .fault_pc    (fault_pc),
  .next_pc     (next_pc),
  .fsr_code    (fsr_code),
  .fsr_domain  (fsr_domain),
  .far_q       (far_q),
  .link_q      (link_q),
  .precise_q   (precise_q),
  .abort_taken (abort_taken)
);

// File: tb/sim_dabt_status_rec.sv
module sim_dabt_status_rec;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          abt_vld = 1'b0;
  logic [7:0]    cause = '0;
  logic          is_page = 1'b0;
  logic [3:0]    domain_in = '0;
  logic [AW-1:0] eff_addr = '0;
  logic [AW-1:0] fault_pc = '0;
  logic [AW-1:0] next_pc = '0;
  logic [4:0]    fsr_code;
  logic [3:0]    fsr_domain;
  logic [AW-1:0] far_q;
  logic [AW-1:0] link_q;
  logic          precise_q;
  logic          abort_taken;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // behavioural model state
  logic [4:0]    m_code = '0;
  logic [3:0]    m_dom = '0;
  logic [AW-1:0] m_far = '0;
  logic [AW-1:0] m_link = '0;
  logic          m_prec = 1'b0;
  logic          m_taken = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dabt_status_rec #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .abt_vld(abt_vld), .cause(cause), .is_page(is_page),
    .domain_in(domain_in), .eff_addr(eff_addr), .fault_pc(fault_pc), .next_pc(next_pc),
    .fsr_code(fsr_code), .fsr_domain(fsr_domain), .far_q(far_q), .link_q(link_q),
    .precise_q(precise_q), .abort_taken(abort_taken)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge();
    int w;
    w = -1;
    for (int i = 0; i < 8; i++) if (w < 0 && cause[i]) w = i;
    m_taken = abt_vld && (w >= 0);
    if (m_taken) begin
      case (w)
        0: m_code = 5'b00001;
        1: m_code = is_page ? 5'b01110 : 5'b01100;
        2: m_code = is_page ? 5'b00111 : 5'b00101;
        3: m_code = is_page ? 5'b01011 : 5'b01001;
        4: m_code = is_page ? 5'b01111 : 5'b01101;
        5: m_code = 5'b10100;
        6: m_code = 5'b10110;
        default: m_code = 5'b11000;
      endcase
      if (w <= 4) m_far = eff_addr;
      if (w == 3 || w == 4 || ((w == 1 || w == 2) && is_page)) m_dom = domain_in;
      m_prec = (w <= 5);
      m_link = m_prec ? fault_pc + 8 : next_pc + 4;
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " R2/R3 code"}, fsr_code, m_code);
    chk({tag, " R5 domain"}, fsr_domain, m_dom);
    chk({tag, " R4 far"}, far_q, m_far);
    chk({tag, " R6/R7 link"}, link_q, m_link);
    chk({tag, " R6/R7 precise"}, precise_q, m_prec);
    chk({tag, " R8/R9/R10 taken"}, abort_taken, m_taken);
  endtask

  task automatic step(input bit v, input logic [7:0] c, input bit pg, input string tag);
    @(negedge clk);
    abt_vld   = v;
    cause     = c;
    is_page   = pg;
    domain_in = 4'($urandom);
    eff_addr  = $urandom;
    fault_pc  = $urandom;
    next_pc   = $urandom;
    model_edge();
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything at zero even with aborts offered
    abt_vld = 1'b1; cause = 8'hFF; eff_addr = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    @(negedge clk);
    abt_vld = 1'b0; cause = '0;
    rst_n = 1'b1;

    // R2: every cause alone, both qualifier values
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) begin
        step(1'b1, 8'(1 << i), p[0], "R2 single");
        step(1'b0, 8'h00, 1'b0, "R8 idle after");
      end

    // R3: priority mixes
    step(1'b1, 8'hFF, 1'b1, "R3 all set");
    step(1'b1, 8'hC0, 1'b0, "R3 impx over parity");
    step(1'b1, 8'hE0, 1'b0, "R3 lock over imprecise");
    step(1'b1, 8'h18, 1'b1, "R3 domain over perm");
    step(1'b1, 8'h06, 1'b1, "R3 extx over xlat");

    // R9: empty strobe, R10: causes without strobe
    step(1'b1, 8'h00, 1'b1, "R9 empty strobe");
    step(1'b0, 8'h01, 1'b1, "R10 no strobe align");
    step(1'b0, 8'h80, 1'b0, "R10 no strobe parity");

    // R4/R5: held fields after lock / imprecise / section winners
    step(1'b1, 8'h10, 1'b1, "R5 load domain");
    step(1'b1, 8'h20, 1'b1, "R4 lock keeps far");
    step(1'b1, 8'h04, 1'b0, "R5 section keeps domain");
    step(1'b1, 8'h01, 1'b1, "R5 align keeps domain");

    // back-to-back aborts (R8)
    step(1'b1, 8'h40, 1'b0, "R8 back to back a");
    step(1'b1, 8'h08, 1'b0, "R8 back to back b");

    // random mixes
    for (int k = 0; k < 400; k++)
      step(1'($urandom), 8'($urandom) & 8'($urandom), 1'($urandom), "R3 random");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule